// File: doc/BRIEF.md
# Multi-Glitch Sequencer

This block turns one trigger event into a scheduled train of fault-injection windows. A table of up to 32 entries is loaded through a small configuration write port. Each entry holds a wait time in target clock cycles and a repeat count. When the trigger input rises, the sequencer walks the table from entry 0. For each entry it waits out that entry's offset and then opens the glitch window for that entry's repeat count. Each offset is counted from the end of the previous entry's window, or from the trigger for entry 0. After the last active entry it raises a done flag.

The window is combined with the target clock and with an externally generated fast glitch pulse. That pulse already carries the shared fine width and phase. Four output styles are available: clock XOR pulse, clock OR pulse, pulse alone, and the raw window with full width. Two voltage-glitch drive outputs, one for high power and one for low power, each pass the voltage glitch signal only when their own enable bit is set.

Top module: `mg_sequencer`

## Requirements
- R1: A rising edge of `trig_i` is sampled on a clock edge. On that edge the sequence starts. `win_o` for entry 0 rises after offset0+1 further clock edges. A trigger held high does not start another sequence.
- R2: For each entry with a nonzero repeat count R, `win_o` stays high for exactly R consecutive cycles.
- R3: Between the end of one entry's window and the start of the next entry's window, `win_o` stays low for exactly offset+1 cycles, using the next entry's offset.
- R4: The control word is written at address 64. Its bits [4:0] hold the entry count minus one, so from 1 to 32 entries are run. Entry k is written at address 2k for its 32-bit offset and at address 2k+1 for its repeat count.
- R5: An entry with a repeat count of 0 produces no window, but its offset+1 cycles of waiting still elapse before the next entry starts.
- R6: A rising edge of `trig_i` while `busy_o` is high has no effect on the schedule.
- R7: `done_o` rises on the edge where the last entry finishes, and `busy_o` falls on that same edge. `done_o` stays high until the next accepted trigger clears it.
- R8: Control bits [6:5] select the output style for `glitch_o`. 0 gives clk XOR (win AND pulse). 1 gives clk OR (win AND pulse). 2 gives win AND pulse. 3 gives win alone.
- R9: The voltage glitch signal is win AND pulse in styles 0 to 2, and win alone in style 3. `hp_o` equals that signal AND control bit 7. `lp_o` equals that signal AND control bit 8.
- R10: After reset, `win_o`, `busy_o`, `done_o`, `hp_o` and `lp_o` are low, and the output style is 0.
- R11: A repeat count written above 8192 is stored as 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock; also the clock combined into `glitch_o` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address: entry fields or the control word |
| cfg_wdata | input | 32 | Configuration write data |
| trig_i | input | 1 | Trigger; rising-edge sensitive |
| pulse_i | input | 1 | Fast glitch pulse with the shared width and phase |
| glitch_o | output | 1 | Combined clock/glitch output |
| hp_o | output | 1 | High-power voltage glitch drive |
| lp_o | output | 1 | Low-power voltage glitch drive |
| win_o | output | 1 | Current glitch window |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last entry finished |

## Verification
The assertions assume that `trig_i` and the configuration port are synchronous to `clk`. They also assume that the entry count and table contents are not rewritten while `busy_o` is high, since the index bound and the window lengths depend on stable settings. The stimulus only writes the configuration while the block is idle. It changes `trig_i` and `pulse_i` only at falling clock edges, so no input moves near a sampling edge. The retrigger case deliberately drops and raises `trig_i` in the middle of a running window, to exercise the ignore rule without touching the table.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int unsigned DEF_N_ENT   = 32;
  localparam int unsigned DEF_OFS_W   = 32;
  localparam int unsigned DEF_REP_W   = 14;
  localparam int unsigned DEF_REP_MAX = 8192;

  typedef enum logic [1:0] {
    MODE_XOR    = 2'd0,
    MODE_OR     = 2'd1,
    MODE_GLITCH = 2'd2,
    MODE_ENABLE = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIRE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mg_cfg_regs.sv
module mg_cfg_regs
  import mg_pkg::*;
#(
  parameter int unsigned N_ENT   = DEF_N_ENT,
  parameter int unsigned OFS_W   = DEF_OFS_W,
  parameter int unsigned REP_W   = DEF_REP_W,
  parameter int unsigned REP_MAX = DEF_REP_MAX,
  parameter int unsigned IDX_W   = $clog2(N_ENT),
  parameter int unsigned ADDR_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFS_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [REP_W-1:0]  a_rep,
  output logic [OFS_W-1:0]  b_ofs,
  output logic [IDX_W-1:0]  num_m1,
  output out_mode_e         mode,
  output logic              hp_en,
  output logic              lp_en
);
  localparam int unsigned CTL_MODE_LO = IDX_W;
  localparam int unsigned CTL_HP_BIT  = IDX_W + 2;
  localparam int unsigned CTL_LP_BIT  = IDX_W + 3;

  logic [OFS_W-1:0] ofs_q [N_ENT];
  logic [REP_W-1:0] rep_q [N_ENT];

  logic             is_ctl;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_rep_sel;
  logic [REP_W-1:0] rep_sat;

  always_comb begin
    is_ctl     = addr[ADDR_W-1];
    wr_idx     = addr[IDX_W:1];
    wr_rep_sel = addr[0];
    if (wdata > OFS_W'(REP_MAX)) rep_sat = REP_W'(REP_MAX);
    else                         rep_sat = wdata[REP_W-1:0];
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic ofs_en, rep_en;
    assign ofs_en = we && !is_ctl && (wr_idx == IDX_W'(g)) && !wr_rep_sel;
    assign rep_en = we && !is_ctl && (wr_idx == IDX_W'(g)) &&  wr_rep_sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs_q[g] <= '0;
      else if (ofs_en) ofs_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rep_q[g] <= '0;
      else if (rep_en) rep_q[g] <= rep_sat;
    end
  end

  logic ctl_en;
  assign ctl_en = we && is_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_m1 <= '0;
      mode   <= MODE_XOR;
      hp_en  <= 1'b0;
      lp_en  <= 1'b0;
    end else if (ctl_en) begin
      num_m1 <= wdata[IDX_W-1:0];
      mode   <= out_mode_e'(wdata[CTL_MODE_LO+1:CTL_MODE_LO]);
      hp_en  <= wdata[CTL_HP_BIT];
      lp_en  <= wdata[CTL_LP_BIT];
    end
  end

  assign a_rep = rep_q[a_idx];
  assign b_ofs = ofs_q[b_idx];

  // R11: stored repeat counts never exceed the cap
  p_rep_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    a_rep <= REP_W'(REP_MAX));
endmodule

// File: rtl/mg_seq.sv
module mg_seq
  import mg_pkg::*;
#(
  parameter int unsigned N_ENT   = DEF_N_ENT,
  parameter int unsigned OFS_W   = DEF_OFS_W,
  parameter int unsigned REP_W   = DEF_REP_W,
  parameter int unsigned REP_MAX = DEF_REP_MAX,
  parameter int unsigned IDX_W   = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [IDX_W-1:0] num_m1,
  input  logic [REP_W-1:0] a_rep,
  input  logic [OFS_W-1:0] b_ofs,
  output logic [IDX_W-1:0] a_idx,
  output logic [IDX_W-1:0] b_idx,
  output logic             win,
  output logic             busy,
  output logic             done
);
  localparam int unsigned CNT_W = (OFS_W > REP_W) ? OFS_W : REP_W;

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             trig_q;
  logic             rise, last, adv;

  assign rise  = trig && !trig_q;
  assign last  = (idx_q == num_m1);
  assign a_idx = idx_q;
  assign b_idx = (st_q == ST_IDLE) ? '0 : IDX_W'(idx_q + 1'b1);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    adv    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rise) begin
          st_d   = ST_WAIT;
          idx_d  = '0;
          cnt_d  = CNT_W'(b_ofs);
          done_d = 1'b0;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) begin
          if (a_rep != '0) begin
            st_d  = ST_FIRE;
            cnt_d = CNT_W'(a_rep) - CNT_W'(1);
          end else begin
            adv = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_FIRE: begin
        if (cnt_q == '0) adv   = 1'b1;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (adv) begin
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        st_d  = ST_WAIT;
        idx_d = IDX_W'(idx_q + 1'b1);
        cnt_d = CNT_W'(b_ofs);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      trig_q <= trig;
    end
  end

  assign win  = (st_q == ST_FIRE);
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  // R1: an accepted trigger starts at entry 0 with done cleared
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rise) |=> (st_q == ST_WAIT && idx_q == '0 && !done_q));
  // R2: a window count never reaches the repeat cap
  p_fire_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIRE) |-> (cnt_q < CNT_W'(REP_MAX)));
  // R4: the walk never passes the programmed last entry
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (idx_q <= num_m1));
  // R6: a new edge mid-wait leaves the schedule alone
  p_retrig_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && rise && cnt_q != '0) |=>
      (st_q == ST_WAIT && idx_q == $past(idx_q)));
  // R7: done only while idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));
endmodule

// File: rtl/mg_out.sv
module mg_out
  import mg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      win,
  input  logic      pulse,
  input  out_mode_e mode,
  input  logic      hp_en,
  input  logic      lp_en,
  output logic      glitch_o,
  output logic      hp_o,
  output logic      lp_o
);
  logic gated, vsig;

  always_comb begin
    gated = win && pulse;
    vsig  = (mode == MODE_ENABLE) ? win : gated;
    unique case (mode)
      MODE_XOR:    glitch_o = clk ^ gated;
      MODE_OR:     glitch_o = clk | gated;
      MODE_GLITCH: glitch_o = gated;
      MODE_ENABLE: glitch_o = win;
      default:     glitch_o = clk;
    endcase
    hp_o = vsig && hp_en;
    lp_o = vsig && lp_en;
  end

  // R8: full-width output across the whole window in enable style
  p_enable_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win && mode == MODE_ENABLE) |-> glitch_o);
  // R9: drives stay quiet outside a window
  p_drive_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (!hp_o && !lp_o));
endmodule

// File: rtl/mg_sequencer.sv
module mg_sequencer
  import mg_pkg::*;
#(
  parameter int unsigned N_ENT   = DEF_N_ENT,
  parameter int unsigned OFS_W   = DEF_OFS_W,
  parameter int unsigned REP_W   = DEF_REP_W,
  parameter int unsigned REP_MAX = DEF_REP_MAX,
  localparam int unsigned IDX_W  = $clog2(N_ENT),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [OFS_W-1:0]  cfg_wdata,
  input  logic              trig_i,
  input  logic              pulse_i,
  output logic              glitch_o,
  output logic              hp_o,
  output logic              lp_o,
  output logic              win_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [IDX_W-1:0] a_idx, b_idx, num_m1;
  logic [REP_W-1:0] a_rep;
  logic [OFS_W-1:0] b_ofs;
  out_mode_e        mode;
  logic             hp_en, lp_en;

  mg_cfg_regs #(
    .N_ENT(N_ENT), .OFS_W(OFS_W), .REP_W(REP_W), .REP_MAX(REP_MAX),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_int), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .a_idx(a_idx), .b_idx(b_idx), .a_rep(a_rep),
    .b_ofs(b_ofs), .num_m1(num_m1), .mode(mode), .hp_en(hp_en),
    .lp_en(lp_en)
  );

  mg_seq #(
    .N_ENT(N_ENT), .OFS_W(OFS_W), .REP_W(REP_W), .REP_MAX(REP_MAX),
    .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_int), .trig(trig_i), .num_m1(num_m1),
    .a_rep(a_rep), .b_ofs(b_ofs), .a_idx(a_idx), .b_idx(b_idx),
    .win(win_o), .busy(busy_o), .done(done_o)
  );

  mg_out u_out (
    .clk(clk), .rst_n(rst_n_int), .win(win_o), .pulse(pulse_i),
    .mode(mode), .hp_en(hp_en), .lp_en(lp_en), .glitch_o(glitch_o),
    .hp_o(hp_o), .lp_o(lp_o)
  );
endmodule

// File: tb/sim_mg_sequencer.sv
module sim_mg_sequencer;
  localparam int CLK_P = 10;
  localparam int QTR   = CLK_P / 4;

  logic        clk = 1'b0;
  logic        rst_n, cfg_we, trig_i, pulse_i;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        glitch_o, hp_o, lp_o, win_o, busy_o, done_o;

  always #(CLK_P/2) clk = ~clk;

  mg_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_i(trig_i), .pulse_i(pulse_i),
    .glitch_o(glitch_o), .hp_o(hp_o), .lp_o(lp_o), .win_o(win_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_q[$];   // {busy, done, win}
  string      tag_q[$];
  int ent_ofs[32];
  int ent_rep[32];
  int cur_n = 1;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // monitor: pops one expected item per cycle while the queue holds any
  initial begin
    forever begin
      @(posedge clk);
      #(QTR);
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "win_o",  {31'b0, win_o},  {31'b0, e[0]});
        chk(t, "done_o", {31'b0, done_o}, {31'b0, e[1]});
        chk(t, "busy_o", {31'b0, busy_o}, {31'b0, e[2]});
      end
    end
  end

  task automatic push(string tag, logic b, logic d, logic w);
    exp_q.push_back({b, d, w});
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_entry(int i, int o, int r);
    wr({1'b0, i[4:0], 1'b0}, o);
    wr({1'b0, i[4:0], 1'b1}, r);
    ent_ofs[i] = o;
    ent_rep[i] = (r > 8192) ? 8192 : r;   // R11 cap
  endtask

  task automatic set_ctrl(int n, int m, bit hp, bit lp);
    wr(7'd64, {23'b0, lp, hp, m[1:0], 5'(n - 1)});
    cur_n = n;
  endtask

  // driver: raise trigger and queue the expected schedule
  task automatic start_seq(string tag, int tail);
    @(negedge clk);
    trig_i = 1'b1;
    for (int e = 0; e < cur_n; e++) begin
      for (int k = 0; k <= ent_ofs[e]; k++) push(tag, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < ent_rep[e]; k++)  push(tag, 1'b1, 1'b0, 1'b1);
    end
    for (int k = 0; k <= tail; k++) push(tag, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  function automatic logic exp_glitch(int m, logic c, logic w, logic p);
    case (m)
      0: return c ^ (w & p);
      1: return c | (w & p);
      2: return w & p;
      default: return w;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog got hang exp sequence end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    trig_i = 1'b0; pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #(QTR);
    // R10: reset state (style 0, clk low -> glitch_o low)
    chk("R10", "win_o",    {31'b0, win_o},    0);
    chk("R10", "busy_o",   {31'b0, busy_o},   0);
    chk("R10", "done_o",   {31'b0, done_o},   0);
    chk("R10", "hp_o",     {31'b0, hp_o},     0);
    chk("R10", "lp_o",     {31'b0, lp_o},     0);
    chk("R10", "glitch_o", {31'b0, glitch_o}, 0);

    // R1 R2: single entry, trigger held through the tail
    set_entry(0, 3, 4);
    set_ctrl(1, 0, 0, 0);
    start_seq("R1_R2", 4);
    drain();

    // R3 R4: three entries with distinct gaps
    set_entry(0, 5, 2);
    set_entry(1, 0, 3);
    set_entry(2, 7, 1);
    set_ctrl(3, 0, 0, 0);
    start_seq("R3_R4", 1);
    drain();

    // R5: middle entry skipped
    set_entry(0, 1, 2);
    set_entry(1, 4, 0);
    set_entry(2, 2, 3);
    start_seq("R5", 1);
    drain();

    // R7: last entry skipped, done after its wait
    set_entry(0, 3, 1);
    set_entry(1, 2, 0);
    set_ctrl(2, 0, 0, 0);
    start_seq("R7", 2);
    drain();

    // R6: retrigger in the middle of a window
    set_entry(0, 2, 30);
    set_ctrl(1, 0, 0, 0);
    start_seq("R6", 1);
    repeat (8) @(negedge clk);
    trig_i = 1'b0;
    @(negedge clk);
    trig_i = 1'b1;
    drain();

    // R4: all 32 entries
    for (int i = 0; i < 32; i++) set_entry(i, i % 3, 1 + (i % 2));
    set_ctrl(32, 0, 0, 0);
    start_seq("R4", 1);
    drain();

    // R11: oversize repeat saturates
    set_entry(0, 0, 32'h0000_FFFF);
    set_ctrl(1, 0, 0, 0);
    start_seq("R11", 1);
    drain();

    // R8 R9: each output style inside and outside the window
    set_entry(0, 2, 40);
    for (int m = 0; m < 4; m++) begin
      bit lpb;
      lpb = m[0];
      set_ctrl(1, m, 1'b1, lpb);
      start_seq("R8_R9", 1);
      repeat (8) @(posedge clk);
      for (int p = 0; p < 2; p++) begin
        logic vs;
        vs = (m == 3) ? 1'b1 : p[0];
        @(negedge clk);
        pulse_i = p[0];
        #(QTR);
        chk("R8", "glitch_o lowclk", {31'b0, glitch_o}, {31'b0, exp_glitch(m, 1'b0, 1'b1, p[0])});
        chk("R9", "hp_o", {31'b0, hp_o}, {31'b0, vs});
        chk("R9", "lp_o", {31'b0, lp_o}, {31'b0, vs & lpb});
        @(posedge clk);
        #(QTR);
        chk("R8", "glitch_o highclk", {31'b0, glitch_o}, {31'b0, exp_glitch(m, 1'b1, 1'b1, p[0])});
      end
      @(negedge clk);
      pulse_i = 1'b0;
      drain();
      @(negedge clk);
      pulse_i = 1'b1;
      #(QTR);
      chk("R8", "glitch_o idle", {31'b0, glitch_o}, {31'b0, exp_glitch(m, 1'b0, 1'b0, 1'b1)});
      chk("R9", "hp_o idle", {31'b0, hp_o}, 0);
      chk("R9", "lp_o idle", {31'b0, lp_o}, 0);
      pulse_i = 1'b0;
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule